// File: doc/BRIEF.md
# Packet header interpreter

This block watches the character stream arriving on one serial link channel and, in protocol mode, decodes a four-character header at the front of each packet. A header is expected right after an end-of-packet marker. Once the fourth header character arrives, the block settles the packet's fate in one of three ways. It opens the path into the receive FIFO for the packet body, or it hands a simple control command to a command executor, or it raises an error and discards the rest of the packet. Every header character is also copied to an acknowledge generator through a tap port.

Header byte 0 is the destination address and byte 1 the command code. Bytes 2 and 3 are parameters that travel with a simple command. In transparent or routing mode the channel does not interpret anything: every character is passed straight to the FIFO path. All outputs are registered, one cycle behind the character that causes them.

Top module: `hdr_interp`

## Requirements
- R1: After reset all pulse outputs and `fwd_open` are 0, and the block waits for an end-of-packet marker (`in_ctl`=1, `in_data[0]`=0). Until that marker arrives, data characters and error-end markers (`in_ctl`=1, `in_data[0]`=1) produce no tap, FIFO write, command or error.
- R2: Each of the four data characters after an end-of-packet marker appears on `hdr_data` with `hdr_vld` high and `hdr_idx` = 0,1,2,3 in the cycle after it is accepted.
- R3: When byte 0 equals `own_addr` and byte 1 equals the data command (default 8'h01), `fwd_open` rises in the cycle after the fourth header character. Every following character, including the end marker that closes the packet, is written out with `fifo_wr` one cycle after it is accepted. `fwd_open` falls in that same cycle.
- R4: When byte 0 matches and byte 1 is a simple command (upper five bits 5'b00010 by default, i.e. 8'h10 to 8'h17) that is not safety-critical (bit 2 = 0), `cmd_req` pulses for one cycle after the fourth header character. It carries `cmd_code` = byte 1 bits 2:0 and `cmd_arg` = {byte 2, byte 3}. The packet body is discarded.
- R5: A simple command with bit 2 = 1 is safety-critical. It is issued as in R4 only if `cmd_armed` was 1 when the fourth header character was accepted. Otherwise an error with cause 3 is raised and no request is made.
- R6: When byte 0 differs from `own_addr`, an error with cause 1 is raised whatever the command is, and the packet body is discarded.
- R7: When the address matches and byte 1 is neither the data command nor a simple command, an error with cause 2 is raised and the body is discarded.
- R8: An end-of-packet or error-end marker that arrives before the fourth header character aborts the header with no outcome. The next data character is taken as header byte 0.
- R9: Either end marker that closes a forwarded or discarded packet makes the next data character header byte 0.
- R10: While `proto_off` is 1, every accepted character is written to the FIFO path one cycle later and no tap, command or error is produced. After `proto_off` returns to 0, the block again waits for an end-of-packet marker as in R1.
- R11: `err_vld` is a single-cycle pulse, and `err_cause` is 1 (address), 2 (command) or 3 (disarmed safety command) whenever it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| proto_off | input | 1 | 1 = transparent/routing mode, interpreter bypassed |
| own_addr | input | CW | Channel address compared with header byte 0 |
| cmd_armed | input | 1 | Safety-critical commands are allowed when 1 |
| in_vld | input | 1 | Input character valid |
| in_ctl | input | 1 | 1 = control character (bit 0 of data: 0 end-of-packet, 1 error-end) |
| in_data | input | CW | Character value |
| fwd_open | output | 1 | Packet body path into the receive FIFO is open |
| fifo_wr | output | 1 | FIFO write strobe |
| fifo_ctl | output | 1 | Control flag of the written character |
| fifo_data | output | CW | Written character |
| cmd_req | output | 1 | Simple command request pulse |
| cmd_code | output | 3 | Command selector |
| cmd_arg | output | 2*CW | Header bytes 2 and 3 |
| hdr_vld | output | 1 | Header character tap valid |
| hdr_idx | output | 2 | Position of the tapped character in the header |
| hdr_data | output | CW | Tapped header character |
| err_vld | output | 1 | Error pulse |
| err_cause | output | 2 | 1 address, 2 command, 3 disarmed safety command |

## Verification
Every result is due exactly one clock after the character that causes it. The tap, the FIFO write and the body-path change follow each character. The command request or error follows the fourth header character. The bench drives characters at falling edges and updates a behavioural model with each rising edge. It then compares all outputs at the following falling edge, so each expected value is checked in the cycle the design should present it. Scenarios cover each outcome, headers cut short by either end marker, idle gaps between characters, and the bypass mode with its return to waiting.

// File: rtl/hdr_interp.sv
module hdr_interp #(
  parameter int CW = 8,
  parameter logic [CW-1:0] DATA_CMD = 8'h01,
  parameter logic [CW-4:0] SIMPLE_TAG = 5'b00010
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            proto_off,
  input  logic [CW-1:0]   own_addr,
  input  logic            cmd_armed,
  input  logic            in_vld,
  input  logic            in_ctl,
  input  logic [CW-1:0]   in_data,
  output logic            fwd_open,
  output logic            fifo_wr,
  output logic            fifo_ctl,
  output logic [CW-1:0]   fifo_data,
  output logic            cmd_req,
  output logic [2:0]      cmd_code,
  output logic [2*CW-1:0] cmd_arg,
  output logic            hdr_vld,
  output logic [1:0]      hdr_idx,
  output logic [CW-1:0]   hdr_data,
  output logic            err_vld,
  output logic [1:0]      err_cause
);

  typedef enum logic [1:0] {S_WAIT, S_HDR, S_BODY, S_DROP} st_t;

  st_t           st;
  logic [1:0]    idx;
  logic [CW-1:0] h0, h1, h2;

  wire is_eop   = in_vld & in_ctl & ~in_data[0];
  wire is_end   = in_vld & in_ctl;
  wire is_dat   = in_vld & ~in_ctl;
  wire addr_ok  = (h0 == own_addr);
  wire c_data   = (h1 == DATA_CMD);
  wire c_simple = (h1[CW-1:3] == SIMPLE_TAG);
  wire c_safe   = h1[2];

  assign fwd_open = (st == S_BODY);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_WAIT;
      idx <= '0;
      h0 <= '0;
      h1 <= '0;
      h2 <= '0;
      fifo_wr <= 1'b0;
      fifo_ctl <= 1'b0;
      fifo_data <= '0;
      cmd_req <= 1'b0;
      cmd_code <= '0;
      cmd_arg <= '0;
      hdr_vld <= 1'b0;
      hdr_idx <= '0;
      hdr_data <= '0;
      err_vld <= 1'b0;
      err_cause <= '0;
    end else begin
      fifo_wr <= 1'b0;
      cmd_req <= 1'b0;
      hdr_vld <= 1'b0;
      err_vld <= 1'b0;
      if (proto_off) begin
        st <= S_WAIT;
        idx <= '0;
        fifo_wr <= in_vld;
        fifo_ctl <= in_ctl;
        fifo_data <= in_data;
      end else begin
        case (st)
          S_WAIT: if (is_eop) begin
            st <= S_HDR;
            idx <= '0;
          end
          S_HDR: begin
            if (is_end) begin
              idx <= '0;
            end else if (is_dat) begin
              hdr_vld <= 1'b1;
              hdr_idx <= idx;
              hdr_data <= in_data;
              idx <= idx + 2'd1;
              case (idx)
                2'd0: h0 <= in_data;
                2'd1: h1 <= in_data;
                2'd2: h2 <= in_data;
                default: begin
                  if (!addr_ok) begin
                    err_vld <= 1'b1;
                    err_cause <= 2'd1;
                    st <= S_DROP;
                  end else if (c_data) begin
                    st <= S_BODY;
                  end else if (c_simple && c_safe && !cmd_armed) begin
                    err_vld <= 1'b1;
                    err_cause <= 2'd3;
                    st <= S_DROP;
                  end else if (c_simple) begin
                    cmd_req <= 1'b1;
                    cmd_code <= h1[2:0];
                    cmd_arg <= {h2, in_data};
                    st <= S_DROP;
                  end else begin
                    err_vld <= 1'b1;
                    err_cause <= 2'd2;
                    st <= S_DROP;
                  end
                end
              endcase
            end
          end
          S_BODY: if (in_vld) begin
            fifo_wr <= 1'b1;
            fifo_ctl <= in_ctl;
            fifo_data <= in_data;
            if (in_ctl) begin
              st <= S_HDR;
              idx <= '0;
            end
          end
          default: if (is_end) begin
            st <= S_HDR;
            idx <= '0;
          end
        endcase
      end
    end
  end

  assert_bypass_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    proto_off |=> (!hdr_vld && !err_vld && !cmd_req));

  assert_no_write_closed_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!proto_off && !fwd_open) |=> !fifo_wr);

  assert_open_after_hdr_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(fwd_open) |-> (hdr_vld && hdr_idx == 2'd3));

  assert_safety_armed_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_req && cmd_code[2]) |-> $past(cmd_armed));

  assert_err_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |-> (err_cause != 2'd0));

  assert_err_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    err_vld |=> !err_vld);

  assert_one_outcome_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_vld && cmd_req));

endmodule

// File: tb/sim_hdr_interp.sv
module sim_hdr_interp;
  localparam int CLK_NS = 10;
  localparam logic [7:0] OWN = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic proto_off = 1'b0;
  logic cmd_armed = 1'b0;
  logic in_vld = 1'b0;
  logic in_ctl = 1'b0;
  logic [7:0] in_data = 8'h00;

  logic fwd_open, fifo_wr, fifo_ctl, cmd_req, hdr_vld, err_vld;
  logic [7:0] fifo_data, hdr_data;
  logic [2:0] cmd_code;
  logic [15:0] cmd_arg;
  logic [1:0] hdr_idx, err_cause;

  hdr_interp u0 (
    .clk(clk), .rst_n(rst_n), .proto_off(proto_off), .own_addr(OWN),
    .cmd_armed(cmd_armed), .in_vld(in_vld), .in_ctl(in_ctl), .in_data(in_data),
    .fwd_open(fwd_open), .fifo_wr(fifo_wr), .fifo_ctl(fifo_ctl), .fifo_data(fifo_data),
    .cmd_req(cmd_req), .cmd_code(cmd_code), .cmd_arg(cmd_arg),
    .hdr_vld(hdr_vld), .hdr_idx(hdr_idx), .hdr_data(hdr_data),
    .err_vld(err_vld), .err_cause(err_cause)
  );

  always #(CLK_NS/2) clk = ~clk;

  int checks = 0;
  int fails = 0;
  int cyc = 0;
  string tag = "R1";

  // behavioural reference: mode 0 waiting, 1 header, 2 forwarding, 3 discarding
  int mode = 0;
  logic [7:0] hq[$];
  logic e_fwd = 0, e_wr = 0, e_fctl = 0, e_cmd = 0, e_hv = 0, e_err = 0;
  logic [7:0] e_fdat = 0, e_hd = 0;
  logic [2:0] e_code = 0;
  logic [15:0] e_arg = 0;
  logic [1:0] e_hi = 0, e_cause = 0;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    e_wr = 0; e_cmd = 0; e_hv = 0; e_err = 0;
    if (!rst_n) begin
      mode = 0; hq.delete(); e_fwd = 0;
    end else if (proto_off) begin
      mode = 0;
      e_wr = in_vld; e_fctl = in_ctl; e_fdat = in_data;
    end else if (in_vld) begin
      if (mode == 0) begin
        if (in_ctl && !in_data[0]) begin mode = 1; hq.delete(); end
      end else if (mode == 1) begin
        if (in_ctl) hq.delete();
        else begin
          e_hv = 1; e_hi = 2'(hq.size()); e_hd = in_data;
          hq.push_back(in_data);
          if (hq.size() == 4) begin
            mode = 3;
            if (hq[0] != OWN) begin e_err = 1; e_cause = 1; end
            else if (hq[1] == 8'h01) mode = 2;
            else if (hq[1] >= 8'h10 && hq[1] <= 8'h17) begin
              if (hq[1] >= 8'h14 && !cmd_armed) begin e_err = 1; e_cause = 3; end
              else begin e_cmd = 1; e_code = hq[1][2:0]; e_arg = {hq[2], hq[3]}; end
            end else begin e_err = 1; e_cause = 2; end
            hq.delete();
          end
        end
      end else if (mode == 2) begin
        e_wr = 1; e_fctl = in_ctl; e_fdat = in_data;
        if (in_ctl) mode = 1;
      end else begin
        if (in_ctl) mode = 1;
      end
    end
    e_fwd = (mode == 2);
  end

  task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h at cycle %0d", tag, what, act, exp, cyc);
    end
  endtask

  always @(negedge clk) begin
    if (cyc >= 1) begin
      chk("fwd_open", 32'(fwd_open), 32'(e_fwd));
      chk("fifo_wr", 32'(fifo_wr), 32'(e_wr));
      if (e_wr) begin
        chk("fifo_data", 32'(fifo_data), 32'(e_fdat));
        chk("fifo_ctl", 32'(fifo_ctl), 32'(e_fctl));
      end
      chk("hdr_vld", 32'(hdr_vld), 32'(e_hv));
      if (e_hv) begin
        chk("hdr_idx", 32'(hdr_idx), 32'(e_hi));
        chk("hdr_data", 32'(hdr_data), 32'(e_hd));
      end
      chk("cmd_req", 32'(cmd_req), 32'(e_cmd));
      if (e_cmd) begin
        chk("cmd_code", 32'(cmd_code), 32'(e_code));
        chk("cmd_arg", 32'(cmd_arg), 32'(e_arg));
      end
      chk("err_vld", 32'(err_vld), 32'(e_err));
      if (e_err) chk("err_cause R11", 32'(err_cause), 32'(e_cause));
    end
  end

  task automatic put(input logic c, input logic [7:0] d);
    in_vld = 1; in_ctl = c; in_data = d;
    @(negedge clk);
    in_vld = 0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic hdr(input logic [7:0] a, input logic [7:0] c, input logic [7:0] p, input logic [7:0] q);
    put(0, a); put(0, c); idle(1); put(0, p); put(0, q);
  endtask

  localparam logic [7:0] EOP = 8'h00;
  localparam logic [7:0] EEP = 8'h01;

  initial begin
    @(negedge clk); @(negedge clk);
    tag = "R1 reset";
    idle(1);
    rst_n = 1;
    tag = "R1 pre-marker";
    put(0, 8'h5A); put(0, 8'h01); put(1, EEP); put(0, 8'h5A); put(0, 8'h01); put(0, 8'h22); put(0, 8'h33); put(0, 8'h44);
    idle(2);
    tag = "R2 R3 data packet";
    put(1, EOP);
    hdr(OWN, 8'h01, 8'hAB, 8'hCD);
    put(0, 8'h11); idle(1); put(0, 8'h22); put(0, 8'h33); put(1, EOP);
    tag = "R3 empty body";
    hdr(OWN, 8'h01, 8'h00, 8'h00); put(1, EOP);
    tag = "R4 simple command";
    hdr(OWN, 8'h12, 8'h34, 8'h56); put(0, 8'h77); put(0, 8'h88); put(1, EOP);
    tag = "R5 armed safety";
    cmd_armed = 1;
    hdr(OWN, 8'h15, 8'h9A, 8'hBC); put(1, EOP);
    tag = "R5 disarmed safety";
    cmd_armed = 0;
    hdr(OWN, 8'h16, 8'h01, 8'h02); put(0, 8'h03); put(1, EOP);
    tag = "R6 address mismatch";
    hdr(8'h33, 8'h01, 8'h01, 8'h02); put(0, 8'h55); put(1, EEP);
    tag = "R9 after error-end";
    hdr(OWN, 8'h01, 8'hEE, 8'hFF); put(0, 8'h66); put(1, EEP);
    tag = "R7 unknown command";
    hdr(OWN, 8'h80, 8'h01, 8'h02); put(0, 8'h99); put(1, EOP);
    tag = "R8 short header end-of-packet";
    put(0, OWN); put(0, 8'h01); put(1, EOP);
    hdr(OWN, 8'h13, 8'h42, 8'h24); put(1, EOP);
    tag = "R8 short header error-end";
    put(0, 8'h44); put(1, EEP);
    hdr(OWN, 8'h01, 8'h10, 8'h20); put(0, 8'hA5); put(1, EOP);
    tag = "R10 bypass";
    proto_off = 1;
    put(0, 8'h5A); put(0, 8'h01); put(1, EOP); idle(1); put(0, 8'hC3); put(1, EEP);
    put(0, 8'h5A); put(0, 8'h01);
    proto_off = 0;
    tag = "R10 back to waiting";
    put(0, 8'h5A); put(0, 8'h10); put(0, 8'h00); put(0, 8'h00);
    put(1, EOP);
    hdr(OWN, 8'h10, 8'h01, 8'h01); put(1, EOP);
    tag = "R2 idle tail";
    idle(4);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    #(CLK_NS * 20000);
    fails++;
    $display("FAIL watchdog expired at cycle %0d", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule